// File: doc/BRIEF.md
# NAND Flash Command and Address Sequencer

This block is the device-side front end of a byte-wide, small-page NAND flash model. On each write strobe it looks at the command-latch and address-latch enables, the active-low chip enable and the 8-bit data bus. Command bytes are decoded. Address bytes are gathered into a little-endian address register. The block then decides, byte by byte, whether an operation fires. Read, program and erase requests leave the block as single-cycle pulses that carry the page address, the column or the block byte address. A storage model behind the block acts on those pulses.

Read-ID and read-status answers are loaded into a short response buffer. A host drains that buffer one byte per read strobe. The status byte reports the level of the write-protect pin, a ready flag and an error flag. Program and erase requests are withheld while write protect is asserted. Opcodes the block does not recognise are dropped. Each one raises a one-cycle flag.

Top module: `nand_cmd_seq`

## Requirements
- R1: A command byte is accepted only on a write strobe with `ce_n` low and `cle` high. With `ce_n` high the byte is ignored and the address gathered so far is kept.
- R2: Address bytes are taken on a write strobe with `ale` high and `cle` low, and are stored little-endian. With three address cycles, the third byte of a read sequence fires `rd_req` one cycle later. At that point `rd_page` = {byte2, byte1} and the column is formed from byte0.
- R3: The read opcodes set the column origin. 0x00 sets it to 0, 0x01 sets it to 0x100 and 0x50 sets it to PAGE_BYTES (512). `rd_col` is the origin plus byte0, and the origin returns to 0 after each read request.
- R4: Opcode 0x90 followed by one address byte loads four response bytes. They are returned in the order MFR_ID (0x5A), DEV_ID (0x66), FILL_BYTE (0x3C), 0xC0.
- R5: Opcode 0x70 loads one status byte. Bit 7 is the `wp_n` level at the command strobe, bit 6 is ready (always 1), and bit 0 is error (0). The other bits are 0.
- R6: Opcode 0x10 issues `prog_req` with `prog_addr` equal to the 24-bit address gathered since the last command, typically after 0x80 and three address bytes. The request is issued only when `wp_n` is high.
- R7: Opcode 0xD0 issues `erase_req` with `erase_addr` equal to the gathered address shifted left by 8 bits. The request is issued only when `wp_n` is high.
- R8: Every accepted command byte clears the address register and the address-cycle count.
- R9: Opcode 0xFF sets the current command back to read, zeroes the address, the address count, the column origin and the response length, and leaves only status bit 7 meaningful.
- R10: An unrecognised opcode leaves all state unchanged and pulses `bad_opcode` for one cycle.
- R11: A read strobe with `ce_n` low returns the next response byte on `dout` one cycle later. Past the end of the response it returns 0x00. A read strobe with `ce_n` high leaves `dout` and the read position unchanged.
- R12: `rd_req`, `prog_req` and `erase_req` are single-cycle pulses, at most one of them is high in any cycle, and all are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| wp_n | input | 1 | Write protect, active low |
| we | input | 1 | Write strobe, one cycle per bus byte |
| re | input | 1 | Read strobe, one cycle per response byte |
| din | input | 8 | Bus byte in |
| dout | output | 8 | Response byte out |
| rd_req | output | 1 | Read request pulse |
| rd_page | output | 16 | Page address of the read |
| rd_col | output | 10 | Column of the read, origin included |
| prog_req | output | 1 | Program request pulse |
| prog_addr | output | 24 | Gathered address of the program |
| erase_req | output | 1 | Erase request pulse |
| erase_addr | output | 24 | Block byte address of the erase |
| bad_opcode | output | 1 | Unknown-opcode pulse |

## Verification
Reads are driven with all three read opcodes and random address bytes, so that a wrong column origin, a byte-order swap or early firing shows up as a mismatch on `rd_page` or `rd_col`. Program and erase sequences are randomised against the write-protect level, which separates the address formatting from the gating. Directed sequences place a foreign byte between address cycles to tell the paths apart. The foreign byte is either a command with chip enable high, an unknown opcode, a restart command or a reset. A retained, cleared or corrupted address or origin then gives a different expected page and column. Response draining covers the byte order of the ID, snapshots of the status byte under both protect levels, reads past the end, and strobes with chip enable high.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

   // opcode values seen on the bus
   localparam logic [7:0] OP_RD_A   = 8'h00;
   localparam logic [7:0] OP_RD_B   = 8'h01;
   localparam logic [7:0] OP_RD_SP  = 8'h50;
   localparam logic [7:0] OP_IDENT  = 8'h90;
   localparam logic [7:0] OP_STAT   = 8'h70;
   localparam logic [7:0] OP_RST    = 8'hFF;
   localparam logic [7:0] OP_PSETUP = 8'h80;
   localparam logic [7:0] OP_PCONF  = 8'h10;
   localparam logic [7:0] OP_ESETUP = 8'h60;
   localparam logic [7:0] OP_ECONF  = 8'hD0;

   localparam int ID_LEN = 4;
   localparam logic [7:0] ID_GEOM_SMALL = 8'hC0;

   typedef enum logic [3:0] {
      K_READ, K_IDENT, K_STAT, K_RESET, K_PSETUP,
      K_PCONF, K_ESETUP, K_ECONF, K_BAD
   } kind_e;

   typedef enum logic [1:0] {
      COL_ZERO, COL_HALF, COL_SPARE
   } colsel_e;

endpackage

// File: rtl/nseq_decode.sv
module nseq_decode
   import nseq_pkg::*;
(
   input  logic [7:0] op,
   output kind_e      kind,
   output colsel_e    colsel
);

   always_comb begin
      kind   = K_BAD;
      colsel = COL_ZERO;
      unique case (op)
         OP_RD_A:   kind = K_READ;
         OP_RD_B:   begin kind = K_READ; colsel = COL_HALF;  end
         OP_RD_SP:  begin kind = K_READ; colsel = COL_SPARE; end
         OP_IDENT:  kind = K_IDENT;
         OP_STAT:   kind = K_STAT;
         OP_RST:    kind = K_RESET;
         OP_PSETUP: kind = K_PSETUP;
         OP_PCONF:  kind = K_PCONF;
         OP_ESETUP: kind = K_ESETUP;
         OP_ECONF:  kind = K_ECONF;
         default:   kind = K_BAD;
      endcase
   end

endmodule

// File: rtl/nseq_addr.sv
module nseq_addr #(
   parameter int ADDR_CYC = 3,
   localparam int ADDR_W = ADDR_CYC * 8,
   localparam int CNT_W  = $clog2(ADDR_CYC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              take,
   input  logic [7:0]        din,
   output logic [ADDR_W-1:0] addr_q,
   output logic [ADDR_W-1:0] addr_nx,
   output logic              first,
   output logic              last
);

   logic [CNT_W-1:0] cnt_q;

   // one lane per address cycle; lane i is written by the i-th byte
   for (genvar i = 0; i < ADDR_CYC; i++) begin : g_lane
      assign addr_nx[i*8 +: 8] = (take && cnt_q == CNT_W'(i)) ? din
                                                              : addr_q[i*8 +: 8];
   end

   assign first = take && (cnt_q == '0);
   assign last  = take && (cnt_q == CNT_W'(ADDR_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
      end else if (clr) begin
         addr_q <= '0;
         cnt_q  <= '0;
      end else if (take) begin
         addr_q <= addr_nx;
         if (cnt_q < CNT_W'(ADDR_CYC))
            cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/nseq_resp.sv
module nseq_resp #(
   parameter int DEPTH = 4,
   localparam int PTR_W = $clog2(DEPTH + 1),
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               load,
   input  logic [PTR_W-1:0]   load_len,
   input  logic [DEPTH*8-1:0] load_data,
   input  logic               pop,
   output logic [7:0]         dout
);

   logic [7:0]       mem [DEPTH];
   logic [PTR_W-1:0] len_q;
   logic [PTR_W-1:0] ptr_q;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[i] <= '0;
         else if (load)
            mem[i] <= load_data[i*8 +: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q <= '0;
         ptr_q <= '0;
         dout  <= '0;
      end else if (load) begin
         len_q <= load_len;
         ptr_q <= '0;
      end else if (clear) begin
         len_q <= '0;
         ptr_q <= '0;
      end else if (pop) begin
         if (ptr_q < len_q) begin
            dout  <= mem[ptr_q[IDX_W-1:0]];
            ptr_q <= ptr_q + 1'b1;
         end else begin
            dout <= '0;
         end
      end
   end

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
   import nseq_pkg::*;
#(
   parameter int         PAGE_BYTES = 512,
   parameter int         ADDR_CYC   = 3,
   parameter int         RESP_DEPTH = 4,
   parameter logic [7:0] MFR_ID     = 8'h5A,
   parameter logic [7:0] DEV_ID     = 8'h66,
   parameter logic [7:0] FILL_BYTE  = 8'h3C,
   localparam int ADDR_W = ADDR_CYC * 8,
   localparam int PAGE_W = ADDR_W - 8,
   localparam int COL_W  = $clog2(PAGE_BYTES + 256),
   localparam int PTR_W  = $clog2(RESP_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              cle,
   input  logic              ale,
   input  logic              wp_n,
   input  logic              we,
   input  logic              re,
   input  logic [7:0]        din,
   output logic [7:0]        dout,
   output logic              rd_req,
   output logic [PAGE_W-1:0] rd_page,
   output logic [COL_W-1:0]  rd_col,
   output logic              prog_req,
   output logic [ADDR_W-1:0] prog_addr,
   output logic              erase_req,
   output logic [ADDR_W-1:0] erase_addr,
   output logic              bad_opcode
);

   // elaboration checks on the parameter set
   if (PAGE_BYTES != 256 && PAGE_BYTES != 512) begin : g_bad_page
      $error("nand_cmd_seq: PAGE_BYTES must be 256 or 512");
   end
   if (ADDR_CYC < 2 || ADDR_CYC > 4) begin : g_bad_cyc
      $error("nand_cmd_seq: ADDR_CYC must be 2..4");
   end
   if (RESP_DEPTH < ID_LEN) begin : g_bad_depth
      $error("nand_cmd_seq: RESP_DEPTH must hold the ID response");
   end

   kind_e   kind;
   colsel_e colsel;
   kind_e   cmd_q;
   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] base_sel;

   logic cmd_strobe, accepted, addr_take;
   logic [ADDR_W-1:0] addr_q, addr_nx;
   logic addr_first, addr_last;

   logic                    resp_load;
   logic [PTR_W-1:0]        resp_len;
   logic [RESP_DEPTH*8-1:0] resp_data;
   logic [RESP_DEPTH*8-1:0] id_image;
   logic [7:0]              stat_byte;

   assign cmd_strobe = we && !ce_n && cle;
   assign accepted   = cmd_strobe && (kind != K_BAD);
   assign addr_take  = we && ale && !cle;

   nseq_decode u_dec (
      .op     (din),
      .kind   (kind),
      .colsel (colsel)
   );

   nseq_addr #(.ADDR_CYC(ADDR_CYC)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (accepted),
      .take    (addr_take),
      .din     (din),
      .addr_q  (addr_q),
      .addr_nx (addr_nx),
      .first   (addr_first),
      .last    (addr_last)
   );

   // column origin selected by the read opcode variant
   always_comb begin
      unique case (colsel)
         COL_HALF:  base_sel = COL_W'(256);
         COL_SPARE: base_sel = COL_W'(PAGE_BYTES);
         default:   base_sel = '0;
      endcase
   end

   // identification image, padded to the buffer depth
   for (genvar i = 0; i < RESP_DEPTH; i++) begin : g_id
      if (i == 0) begin : g_b0
         assign id_image[i*8 +: 8] = MFR_ID;
      end else if (i == 1) begin : g_b1
         assign id_image[i*8 +: 8] = DEV_ID;
      end else if (i == 2) begin : g_b2
         assign id_image[i*8 +: 8] = FILL_BYTE;
      end else if (i == 3) begin : g_b3
         assign id_image[i*8 +: 8] = ID_GEOM_SMALL;
      end else begin : g_pad
         assign id_image[i*8 +: 8] = 8'h00;
      end
   end

   // bit7 protect level, bit6 ready, bit0 error
   assign stat_byte = {wp_n, 1'b1, 5'b0, 1'b0};

   always_comb begin
      resp_load = 1'b0;
      resp_len  = '0;
      resp_data = '0;
      if (accepted && kind == K_STAT) begin
         resp_load          = 1'b1;
         resp_len           = PTR_W'(1);
         resp_data[7:0]     = stat_byte;
      end else if (addr_first && cmd_q == K_IDENT) begin
         resp_load = 1'b1;
         resp_len  = PTR_W'(ID_LEN);
         resp_data = id_image;
      end
   end

   nseq_resp #(.DEPTH(RESP_DEPTH)) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (accepted),
      .load      (resp_load),
      .load_len  (resp_len),
      .load_data (resp_data),
      .pop       (re && !ce_n),
      .dout      (dout)
   );

   // command register and column origin
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= K_READ;
         base_q <= '0;
      end else if (accepted) begin
         if (kind == K_RESET) begin
            cmd_q  <= K_READ;
            base_q <= '0;
         end else begin
            cmd_q <= kind;
            if (kind == K_READ)
               base_q <= base_sel;
         end
      end else if (addr_last && cmd_q == K_READ) begin
         base_q <= '0;
      end
   end

   // request pulses
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_req     <= 1'b0;
         rd_page    <= '0;
         rd_col     <= '0;
         prog_req   <= 1'b0;
         prog_addr  <= '0;
         erase_req  <= 1'b0;
         erase_addr <= '0;
         bad_opcode <= 1'b0;
      end else begin
         rd_req     <= 1'b0;
         prog_req   <= 1'b0;
         erase_req  <= 1'b0;
         bad_opcode <= cmd_strobe && (kind == K_BAD);
         if (addr_last && cmd_q == K_READ) begin
            rd_req  <= 1'b1;
            rd_page <= addr_nx[ADDR_W-1:8];
            rd_col  <= base_q + COL_W'(addr_nx[7:0]);
         end
         if (accepted && kind == K_PCONF && wp_n) begin
            prog_req  <= 1'b1;
            prog_addr <= addr_q;
         end
         if (accepted && kind == K_ECONF && wp_n) begin
            erase_req  <= 1'b1;
            erase_addr <= {addr_q[ADDR_W-9:0], 8'h00};
         end
      end
   end

endmodule

// File: rtl/nseq_checker.sv
module nseq_checker #(
   parameter int ADDR_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              cle,
   input logic              wp_n,
   input logic              we,
   input logic              re,
   input logic [7:0]        dout,
   input logic              rd_req,
   input logic              prog_req,
   input logic              erase_req,
   input logic [ADDR_W-1:0] erase_addr,
   input logic              bad_opcode
);

   // R6: program only leaves when protect was released at the confirm strobe
   a_r6_prog_unprotected: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |-> $past(wp_n));

   // R7: erase only leaves when protect was released at the confirm strobe
   a_r7_erase_unprotected: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> $past(wp_n));

   // R1: both confirm pulses come from an enabled command strobe
   a_r1_confirm_source: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_req || erase_req) |-> $past(we && cle && !ce_n));

   // R12: never two requests together, read pulse lasts one cycle
   a_r12_one_request: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_req, prog_req, erase_req}));

   a_r12_read_single: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);

   // R10: unknown-opcode flag only after an enabled command strobe
   a_r10_bad_source: assert property (@(posedge clk) disable iff (!rst_n)
      bad_opcode |-> $past(we && cle && !ce_n));

   // R11: the response byte moves only after an enabled read strobe
   a_r11_dout_source: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dout) |-> $past(re && !ce_n));

   // R7: an erase address is always block aligned to the byte lane
   a_r7_erase_lane: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> (erase_addr[7:0] == 8'h00));

endmodule

bind nand_cmd_seq nseq_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ce_n       (ce_n),
   .cle        (cle),
   .wp_n       (wp_n),
   .we         (we),
   .re         (re),
   .dout       (dout),
   .rd_req     (rd_req),
   .prog_req   (prog_req),
   .erase_req  (erase_req),
   .erase_addr (erase_addr),
   .bad_opcode (bad_opcode)
);

// File: tb/nand_cmd_seq_test.sv
module nand_cmd_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam int PAGE_BYTES = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b0, cle = 1'b0, ale = 1'b0, wp_n = 1'b1;
   logic        we = 1'b0, re = 1'b0;
   logic [7:0]  din = 8'h00;
   logic [7:0]  dout;
   logic        rd_req, prog_req, erase_req, bad_opcode;
   logic [15:0] rd_page;
   logic [9:0]  rd_col;
   logic [23:0] prog_addr, erase_addr;

   int nchk = 0;
   int nerr = 0;

   logic g_rd, g_pr, g_er, g_bad;

   always #(CLK_PERIOD/2) clk = ~clk;

   nand_cmd_seq uut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
      .wp_n(wp_n), .we(we), .re(re), .din(din), .dout(dout),
      .rd_req(rd_req), .rd_page(rd_page), .rd_col(rd_col),
      .prog_req(prog_req), .prog_addr(prog_addr),
      .erase_req(erase_req), .erase_addr(erase_addr),
      .bad_opcode(bad_opcode)
   );

   task automatic check(input string tag, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic int exp_base(input logic [7:0] op);
      if (op == 8'h01) return 256;
      if (op == 8'h50) return PAGE_BYTES;
      return 0;
   endfunction

   function automatic int exp_page(input logic [7:0] b1, input logic [7:0] b2);
      return {b2, b1};
   endfunction

   task automatic bus_wr(input logic c, input logic a, input logic [7:0] b);
      @(negedge clk);
      cle = c; ale = a; din = b; we = 1'b1;
      @(negedge clk);
      we = 1'b0; cle = 1'b0; ale = 1'b0;
      g_rd = rd_req; g_pr = prog_req; g_er = erase_req; g_bad = bad_opcode;
   endtask

   task automatic cmd(input logic [7:0] b);
      bus_wr(1'b1, 1'b0, b);
   endtask

   task automatic adr(input logic [7:0] b);
      bus_wr(1'b0, 1'b1, b);
   endtask

   task automatic rd_byte(output logic [7:0] v);
      @(negedge clk);
      re = 1'b1;
      @(negedge clk);
      re = 1'b0;
      v = dout;
   endtask

   task automatic do_read(input logic [7:0] op, input logic [7:0] b0,
                          input logic [7:0] b1, input logic [7:0] b2,
                          input string tag);
      cmd(op); adr(b0); adr(b1);
      check({tag, " no early fire"}, g_rd, 0);
      adr(b2);
      check({tag, " rd_req"}, g_rd, 1);
      check({tag, " rd_page"}, rd_page, exp_page(b1, b2));
      check({tag, " rd_col"}, rd_col, exp_base(op) + b0);
      @(negedge clk);
      check("R12 read pulse one cycle", rd_req, 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin : main
      logic [7:0] v;
      void'($urandom(32'h00C0FFEE));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state (R12)
      check("R12 reset rd_req", rd_req, 0);
      check("R12 reset prog_req", prog_req, 0);
      check("R12 reset erase_req", erase_req, 0);
      check("R11 reset dout", dout, 0);

      // R4 identification bytes and read past end
      cmd(8'h90); adr(8'h00);
      rd_byte(v); check("R4 id byte0", v, 8'h5A);
      rd_byte(v); check("R4 id byte1", v, 8'h66);
      rd_byte(v); check("R4 id byte2", v, 8'h3C);
      rd_byte(v); check("R4 id byte3", v, 8'hC0);
      rd_byte(v); check("R11 past end", v, 8'h00);

      // R11 read strobe with chip disabled
      cmd(8'h90); adr(8'h00);
      ce_n = 1'b1;
      rd_byte(v); check("R11 disabled read holds dout", v, 8'h00);
      ce_n = 1'b0;
      rd_byte(v); check("R11 position kept", v, 8'h5A);

      // R5 status snapshots
      wp_n = 1'b1; cmd(8'h70);
      rd_byte(v); check("R5 status unprotected", v, 8'hC0);
      wp_n = 1'b0; cmd(8'h70);
      rd_byte(v); check("R5 status protected", v, 8'h40);
      rd_byte(v); check("R11 status past end", v, 8'h00);
      wp_n = 1'b1;

      // R2 / R3 directed reads
      do_read(8'h00, 8'h12, 8'h34, 8'h56, "R2 read0");
      do_read(8'h01, 8'h7F, 8'h34, 8'h12, "R3 read half");
      do_read(8'h50, 8'h0F, 8'hAA, 8'h01, "R3 read spare");

      // R1 command ignored while chip disabled
      cmd(8'h00); adr(8'h05); adr(8'h06);
      ce_n = 1'b1; cmd(8'h70); ce_n = 1'b0;
      adr(8'h07);
      check("R1 disabled cmd ignored rd_req", g_rd, 1);
      check("R1 disabled cmd ignored page", rd_page, 16'h0706);

      // R10 unknown opcode
      cmd(8'h00); adr(8'h01); adr(8'h02);
      check("R10 valid opcode no flag", g_bad, 0);
      cmd(8'h33);
      check("R10 bad_opcode pulse", g_bad, 1);
      adr(8'h03);
      check("R10 state kept rd_req", g_rd, 1);
      check("R10 state kept page", rd_page, 16'h0302);
      check("R10 state kept col", rd_col, 10'h001);

      // R8 accepted command clears address count
      cmd(8'h00); adr(8'h09); adr(8'h09);
      cmd(8'h00); adr(8'h01);
      check("R8 count cleared", g_rd, 0);
      adr(8'h02);
      check("R8 count cleared 2", g_rd, 0);
      adr(8'h03);
      check("R8 fire after restart", g_rd, 1);
      check("R8 page after restart", rd_page, 16'h0302);

      // R9 reset command
      cmd(8'h50); cmd(8'hFF);
      adr(8'h04); adr(8'h05); adr(8'h06);
      check("R9 reset returns to read", g_rd, 1);
      check("R9 reset clears origin", rd_col, 10'h004);
      cmd(8'h70); cmd(8'hFF);
      rd_byte(v); check("R9 reset clears response", v, 8'h00);

      // R6 program with and without protect
      wp_n = 1'b1;
      cmd(8'h80); adr(8'h11); adr(8'h22); adr(8'h33); cmd(8'h10);
      check("R6 prog_req", g_pr, 1);
      check("R6 prog_addr", prog_addr, 24'h332211);
      wp_n = 1'b0;
      cmd(8'h80); adr(8'h11); adr(8'h22); adr(8'h33); cmd(8'h10);
      check("R6 protected no prog", g_pr, 0);

      // R7 erase with and without protect
      wp_n = 1'b1;
      cmd(8'h60); adr(8'h44); adr(8'h55); cmd(8'hD0);
      check("R7 erase_req", g_er, 1);
      check("R7 erase_addr", erase_addr, 24'h554400);
      wp_n = 1'b0;
      cmd(8'h60); adr(8'h44); adr(8'h55); cmd(8'hD0);
      check("R7 protected no erase", g_er, 0);
      wp_n = 1'b1;

      // random mix
      for (int it = 0; it < 60; it++) begin
         int sel;
         logic [7:0] b0, b1, b2, op;
         logic wp;
         sel = $urandom % 3;
         b0 = 8'($urandom); b1 = 8'($urandom); b2 = 8'($urandom);
         wp = 1'($urandom);
         if (sel == 0) begin
            case ($urandom % 3)
               0: op = 8'h00;
               1: op = 8'h01;
               default: op = 8'h50;
            endcase
            do_read(op, b0, b1, b2, "R3 random read");
         end else if (sel == 1) begin
            wp_n = wp;
            cmd(8'h80); adr(b0); adr(b1); adr(b2); cmd(8'h10);
            check("R6 random prog_req", g_pr, int'(wp));
            if (wp) check("R6 random prog_addr", prog_addr, {b2, b1, b0});
         end else begin
            wp_n = wp;
            cmd(8'h60); adr(b0); adr(b1); cmd(8'hD0);
            check("R7 random erase_req", g_er, int'(wp));
            if (wp) check("R7 random erase_addr", erase_addr, {b1, b0, 8'h00});
         end
         wp_n = 1'b1;
      end

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule